// File: doc/BRIEF.md
# Dual Multiply-Accumulate Datapath

This block is a two-stage arithmetic datapath for a signal-processing core. Two 32-bit operand words arrive with each issued command. Each word is split into a signed upper half and a signed lower half. The two upper halves are multiplied together, and so are the two lower halves, so two signed 16x16 products are formed in the same cycle. Each 32-bit product lands in its own product register.

In the following cycle the products feed two arithmetic units:

- a 40-bit two-input ALU, which adds, subtracts, applies bitwise logic or passes a value through;
- a 40-bit adder, which sums an accumulator with one or both products, optionally negated.

Both units read from a file of eight 40-bit accumulators and write back into it. Each unit has its own source select, destination select and write enable. A route bit picks which product goes to the ALU. The adder takes the other product, or both products in three-input mode.

Optional saturation clamps arithmetic results to the signed 32-bit range and records the event in a sticky overflow flag. The accumulator contents are seen through two combinational read ports. These ports can clamp the value they present without changing what is stored.

Top module: `dmac_core`

## Requirements
- R1: After a synchronous reset every accumulator reads zero and `ovf` is low.
- R2: Lane 0 product = signed `x_word[31:16]` times signed `y_word[31:16]`. Lane 1 product = signed `x_word[15:0]` times signed `y_word[15:0]`. Both are sign-extended to 40 bits before any accumulation.
- R3: With `swap`=0 the ALU receives the lane 0 product and the adder's primary input is the lane 1 product. With `swap`=1 the two are exchanged. In three-input mode the adder's secondary input is the product not chosen as primary.
- R4: ALU function codes (result from accumulator A = `acc[alu_src]` and product P):
  - 0: A+P
  - 1: A-P
  - 2: A AND P
  - 3: A OR P
  - 4: A XOR P
  - 5: P
  - 6 and 7: A unchanged
- R5: The adder result is `acc[add_src]` plus the primary product, plus the secondary product when `add_three`=1. When `add_neg`=1 every product term is subtracted instead of added.
- R6: The ALU result is written to `acc[alu_dst]` when `alu_we`=1, and the adder result to `acc[add_dst]` when `add_we`=1. Both units read source values from before that cycle's writes. When both write the same accumulator, the adder's result is kept.
- R7: Operands and command are sampled on the rising edge where `issue`=1. Destination accumulators are unchanged after that edge and take their new values on the next rising edge. A command issued in the immediately following cycle sees those new values.
- R8: With `sat_en`=1, results of ALU codes 0, 1 and 5 and all adder results are clamped to the range 0xFF80000000..0x007FFFFFFF. The bounds themselves are kept unclamped. With `sat_en`=0 results wrap modulo 2^40. Logic codes are never clamped.
- R9: `ovf` rises one cycle after an enabled write whose result was clamped. It stays high until reset.
- R10: `rd_a`/`rd_b` show `acc[rd_sel_a]`/`acc[rd_sel_b]` combinationally. With `rd_sat`=1 both are clamped to the R8 range and the stored values are unchanged.
- R11: Cycles without `issue`, and issued commands with both write enables low, leave every accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue | input | 1 | Accept operands and command this cycle |
| x_word | input | 32 | First packed operand word (two signed halves) |
| y_word | input | 32 | Second packed operand word (two signed halves) |
| alu_fn | input | 3 | ALU function code |
| alu_we | input | 1 | ALU result write enable |
| alu_src | input | 3 | ALU accumulator source |
| alu_dst | input | 3 | ALU accumulator destination |
| add_we | input | 1 | Adder result write enable |
| add_src | input | 3 | Adder accumulator source |
| add_dst | input | 3 | Adder accumulator destination |
| add_three | input | 1 | Adder sums both products |
| add_neg | input | 1 | Adder subtracts its product terms |
| swap | input | 1 | Exchange product routing |
| sat_en | input | 1 | Clamp arithmetic results |
| rd_sel_a | input | 3 | Read port A accumulator select |
| rd_sel_b | input | 3 | Read port B accumulator select |
| rd_sat | input | 1 | Clamp values on both read ports |
| rd_a | output | 40 | Read port A data |
| rd_b | output | 40 | Read port B data |
| ovf | output | 1 | Sticky saturation flag |

## Verification
The assertions take for granted that `rst` is held for at least one edge before `issue` is first raised. They also assume the command fields are stable in the cycle `issue` is high. The bench meets both conditions by driving every input on the falling edge and holding `issue` low throughout reset.

The product-hold and accumulator-hold properties further assume that `issue` alone governs when operands are consumed. The stimulus therefore changes operand words freely while `issue` is low, to show that those changes have no effect. The sweep covers the extreme 16-bit values (-32768, 32767, -1, 0). This reaches both clamp bounds and accumulators far beyond the 32-bit range, while keeping all sums within the 42-bit internal width the checks rely on.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    parameter int HALF_W = 16;
    parameter int WORD_W = 2 * HALF_W;
    parameter int PROD_W = 2 * HALF_W;
    parameter int ACC_W  = 40;
    parameter int WIDE_W = ACC_W + 2;
    parameter int ACC_N  = 8;
    parameter int IDX_W  = $clog2(ACC_N);
    parameter int LIM_W  = 32;
    parameter int LANES  = 2;

    localparam longint LIM_HI_L = (longint'(1) <<< (LIM_W - 1)) - 1;
    localparam longint LIM_LO_L = -(longint'(1) <<< (LIM_W - 1));

    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    localparam wide_t LIM_HI = wide_t'(LIM_HI_L);
    localparam wide_t LIM_LO = wide_t'(LIM_LO_L);

    typedef enum logic [2:0] {
        FN_ADD  = 3'd0,
        FN_SUB  = 3'd1,
        FN_AND  = 3'd2,
        FN_OR   = 3'd3,
        FN_XOR  = 3'd4,
        FN_PASS = 3'd5,
        FN_KEEP = 3'd6,
        FN_KEEP2 = 3'd7
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e          fn;
        logic             alu_we;
        logic [IDX_W-1:0] alu_src;
        logic [IDX_W-1:0] alu_dst;
        logic             add_we;
        logic [IDX_W-1:0] add_src;
        logic [IDX_W-1:0] add_dst;
        logic             three;
        logic             neg;
        logic             swap;
        logic             sat;
    } cmd_t;

    typedef struct packed {
        acc_t val;
        logic clip;
    } sat_res_t;

    function automatic wide_t widen(acc_t a);
        return wide_t'(a);
    endfunction

    function automatic acc_t ext_prod(prod_t p);
        return acc_t'(p);
    endfunction

    function automatic sat_res_t limit(wide_t v, logic en);
        sat_res_t r;
        r.val  = v[ACC_W-1:0];
        r.clip = 1'b0;
        if (en && (v > LIM_HI)) begin
            r.val  = LIM_HI[ACC_W-1:0];
            r.clip = 1'b1;
        end else if (en && (v < LIM_LO)) begin
            r.val  = LIM_LO[ACC_W-1:0];
            r.clip = 1'b1;
        end
        return r;
    endfunction

    function automatic acc_t clamp_acc(acc_t a);
        sat_res_t r;
        r = limit(widen(a), 1'b1);
        return r.val;
    endfunction

    function automatic logic fits(acc_t a);
        return (widen(a) <= LIM_HI) && (widen(a) >= LIM_LO);
    endfunction
endpackage

// File: rtl/dmac_mul.sv
module dmac_mul
    import dmac_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          issue,
    input  logic [WORD_W-1:0]             x_word,
    input  logic [WORD_W-1:0]             y_word,
    input  cmd_t                          cmd_in,
    output logic [LANES-1:0][PROD_W-1:0]  prod_q,
    output cmd_t                          cmd_q,
    output logic                          vld_q
);
    // Lane 0 takes the upper halves, lane 1 the lower halves.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic signed [HALF_W-1:0] xa;
        logic signed [HALF_W-1:0] ya;
        prod_t                    pr;
        prod_t                    pr_q;

        assign xa = x_word[(LANES - g) * HALF_W - 1 -: HALF_W];
        assign ya = y_word[(LANES - g) * HALF_W - 1 -: HALF_W];
        assign pr = xa * ya;

        always_ff @(posedge clk) begin
            if (rst)        pr_q <= '0;
            else if (issue) pr_q <= pr;
        end

        assign prod_q[g] = pr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= issue;
            if (issue) cmd_q <= cmd_in;
        end
    end

    // R7
    prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !issue |=> $stable(prod_q));
endmodule

// File: rtl/dmac_alu.sv
module dmac_alu
    import dmac_pkg::*;
(
    input  alu_fn_e fn,
    input  acc_t    a,
    input  acc_t    p,
    input  logic    sat,
    output acc_t    res,
    output logic    clip
);
    wide_t    aw;
    wide_t    pw;
    sat_res_t lim;

    assign aw = widen(a);
    assign pw = widen(p);

    always_comb begin
        res  = a;
        clip = 1'b0;
        lim  = '0;
        unique case (fn)
            FN_ADD:  begin lim = limit(aw + pw, sat); res = lim.val; clip = lim.clip; end
            FN_SUB:  begin lim = limit(aw - pw, sat); res = lim.val; clip = lim.clip; end
            FN_PASS: begin lim = limit(pw, sat);      res = lim.val; clip = lim.clip; end
            FN_AND:  res = a & p;
            FN_OR:   res = a | p;
            FN_XOR:  res = a ^ p;
            FN_KEEP, FN_KEEP2: res = a;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/dmac_adder.sv
module dmac_adder
    import dmac_pkg::*;
(
    input  acc_t a,
    input  acc_t pa,
    input  acc_t pb,
    input  logic three,
    input  logic neg,
    input  logic sat,
    output acc_t res,
    output logic clip
);
    wide_t    ta;
    wide_t    tb;
    wide_t    sum;
    sat_res_t lim;

    always_comb begin
        ta   = neg ? -widen(pa) : widen(pa);
        tb   = three ? (neg ? -widen(pb) : widen(pb)) : '0;
        sum  = widen(a) + ta + tb;
        lim  = limit(sum, sat);
        res  = lim.val;
        clip = lim.clip;
    end
endmodule

// File: rtl/dmac_accfile.sv
module dmac_accfile
    import dmac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we_lo,
    input  logic [IDX_W-1:0] dst_lo,
    input  acc_t             wd_lo,
    input  logic             we_hi,
    input  logic [IDX_W-1:0] dst_hi,
    input  acc_t             wd_hi,
    input  logic [IDX_W-1:0] src_a,
    input  logic [IDX_W-1:0] src_b,
    output acc_t             val_a,
    output acc_t             val_b,
    input  logic [IDX_W-1:0] rd_sel_a,
    input  logic [IDX_W-1:0] rd_sel_b,
    input  logic             rd_sat,
    output logic [ACC_W-1:0] rd_a,
    output logic [ACC_W-1:0] rd_b
);
    logic [ACC_N-1:0][ACC_W-1:0] acc_q;

    // The high-priority port (adder) overrides the low one on a shared target.
    for (genvar g = 0; g < ACC_N; g++) begin : g_ent
        acc_t ent_q;
        always_ff @(posedge clk) begin
            if (rst)
                ent_q <= '0;
            else if (we_hi && (dst_hi == IDX_W'(g)))
                ent_q <= wd_hi;
            else if (we_lo && (dst_lo == IDX_W'(g)))
                ent_q <= wd_lo;
        end
        assign acc_q[g] = ent_q;
    end

    assign val_a = acc_t'(acc_q[src_a]);
    assign val_b = acc_t'(acc_q[src_b]);

    assign rd_a = rd_sat ? clamp_acc(acc_t'(acc_q[rd_sel_a])) : acc_q[rd_sel_a];
    assign rd_b = rd_sat ? clamp_acc(acc_t'(acc_q[rd_sel_b])) : acc_q[rd_sel_b];

    // R6
    hi_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (we_lo && we_hi && (dst_lo == dst_hi)) |=> (acc_q[$past(dst_hi)] == $past(wd_hi)));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(we_lo || we_hi) |=> $stable(acc_q));

    // R10
    rd_clamp_chk: assert property (@(posedge clk) disable iff (rst)
        rd_sat |-> (fits(rd_a) && fits(rd_b)));
endmodule

// File: rtl/dmac_core.sv
module dmac_core
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              issue,
    input  logic [WORD_W-1:0] x_word,
    input  logic [WORD_W-1:0] y_word,
    input  logic [2:0]        alu_fn,
    input  logic              alu_we,
    input  logic [IDX_W-1:0]  alu_src,
    input  logic [IDX_W-1:0]  alu_dst,
    input  logic              add_we,
    input  logic [IDX_W-1:0]  add_src,
    input  logic [IDX_W-1:0]  add_dst,
    input  logic              add_three,
    input  logic              add_neg,
    input  logic              swap,
    input  logic              sat_en,
    input  logic [IDX_W-1:0]  rd_sel_a,
    input  logic [IDX_W-1:0]  rd_sel_b,
    input  logic              rd_sat,
    output logic [ACC_W-1:0]  rd_a,
    output logic [ACC_W-1:0]  rd_b,
    output logic              ovf
);
    cmd_t                         cmd_in;
    cmd_t                         s2;
    logic                         s2_vld;
    logic [LANES-1:0][PROD_W-1:0] prod_q;
    acc_t                         p_alu;
    acc_t                         p_pri;
    acc_t                         p_sec;
    acc_t                         src_alu;
    acc_t                         src_add;
    acc_t                         alu_res;
    acc_t                         add_res;
    logic                         alu_clip;
    logic                         add_clip;
    logic                         we_alu;
    logic                         we_add;

    always_comb begin
        cmd_in.fn      = alu_fn_e'(alu_fn);
        cmd_in.alu_we  = alu_we;
        cmd_in.alu_src = alu_src;
        cmd_in.alu_dst = alu_dst;
        cmd_in.add_we  = add_we;
        cmd_in.add_src = add_src;
        cmd_in.add_dst = add_dst;
        cmd_in.three   = add_three;
        cmd_in.neg     = add_neg;
        cmd_in.swap    = swap;
        cmd_in.sat     = sat_en;
    end

    // Stage 1: operand split, two multipliers, product registers.
    dmac_mul u_mul (
        .clk    (clk),
        .rst    (rst),
        .issue  (issue),
        .x_word (x_word),
        .y_word (y_word),
        .cmd_in (cmd_in),
        .prod_q (prod_q),
        .cmd_q  (s2),
        .vld_q  (s2_vld)
    );

    // Stage 2: routing, ALU, adder, accumulator write.
    assign p_alu = s2.swap ? ext_prod(prod_q[1]) : ext_prod(prod_q[0]);
    assign p_pri = s2.swap ? ext_prod(prod_q[0]) : ext_prod(prod_q[1]);
    assign p_sec = p_alu;

    dmac_alu u_alu (
        .fn   (s2.fn),
        .a    (src_alu),
        .p    (p_alu),
        .sat  (s2.sat),
        .res  (alu_res),
        .clip (alu_clip)
    );

    dmac_adder u_add (
        .a     (src_add),
        .pa    (p_pri),
        .pb    (p_sec),
        .three (s2.three),
        .neg   (s2.neg),
        .sat   (s2.sat),
        .res   (add_res),
        .clip  (add_clip)
    );

    assign we_alu = s2_vld && s2.alu_we;
    assign we_add = s2_vld && s2.add_we;

    dmac_accfile u_acc (
        .clk      (clk),
        .rst      (rst),
        .we_lo    (we_alu),
        .dst_lo   (s2.alu_dst),
        .wd_lo    (alu_res),
        .we_hi    (we_add),
        .dst_hi   (s2.add_dst),
        .wd_hi    (add_res),
        .src_a    (s2.alu_src),
        .src_b    (s2.add_src),
        .val_a    (src_alu),
        .val_b    (src_add),
        .rd_sel_a (rd_sel_a),
        .rd_sel_b (rd_sel_b),
        .rd_sat   (rd_sat),
        .rd_a     (rd_a),
        .rd_b     (rd_b)
    );

    always_ff @(posedge clk) begin
        if (rst) ovf <= 1'b0;
        else if ((we_alu && alu_clip) || (we_add && add_clip)) ovf <= 1'b1;
    end

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

    // R8
    sat_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (we_add && s2.sat) |-> fits(add_res));

    // R8
    alu_limit_chk: assert property (@(posedge clk) disable iff (rst)
        (we_alu && s2.sat && (s2.fn == FN_ADD || s2.fn == FN_SUB)) |-> fits(alu_res));
endmodule

// File: tb/dmac_core_test.sv
`timescale 1ns/1ps
module dmac_core_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue;
    logic [31:0] x_word, y_word;
    logic [2:0]  alu_fn;
    logic        alu_we, add_we, add_three, add_neg, swap, sat_en, rd_sat;
    logic [2:0]  alu_src, alu_dst, add_src, add_dst, rd_sel_a, rd_sel_b;
    logic [39:0] rd_a, rd_b;
    logic        ovf;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    typedef struct {
        logic [31:0] x, y;
        int fn; bit awe; int asrc, adst;
        bit dwe; int dsrc, ddst;
        bit three, neg, swp, sat;
    } op_t;

    longint m_acc[8];
    bit     m_ovf;

    localparam longint HI = 64'sh7FFFFFFF;
    localparam longint LO = -HI - 1;

    always #2.5 clk = ~clk;

    dmac_core uut (
        .clk(clk), .rst(rst), .issue(issue), .x_word(x_word), .y_word(y_word),
        .alu_fn(alu_fn), .alu_we(alu_we), .alu_src(alu_src), .alu_dst(alu_dst),
        .add_we(add_we), .add_src(add_src), .add_dst(add_dst),
        .add_three(add_three), .add_neg(add_neg), .swap(swap), .sat_en(sat_en),
        .rd_sel_a(rd_sel_a), .rd_sel_b(rd_sel_b), .rd_sat(rd_sat),
        .rd_a(rd_a), .rd_b(rd_b), .ovf(ovf)
    );

    function automatic longint wrap40(longint v);
        return (v <<< 24) >>> 24;
    endfunction

    function automatic longint lim(longint v, bit en, output bit c);
        c = 0;
        if (en && v > HI) begin c = 1; return HI; end
        if (en && v < LO) begin c = 1; return LO; end
        return wrap40(v);
    endfunction

    function automatic longint rdx(longint v, bit s);
        bit c;
        return s ? lim(v, 1'b1, c) : v;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(int idx, bit s, string tag);
        rd_sel_a = 3'(idx);
        rd_sel_b = 3'((idx + 5) % 8);
        rd_sat   = s;
        #1;
        check(tag, longint'($signed(rd_a)), rdx(m_acc[idx], s));
        check(tag, longint'($signed(rd_b)), rdx(m_acc[(idx + 5) % 8], s));
    endtask

    task automatic drive(op_t o, bit iss);
        issue = iss; x_word = o.x; y_word = o.y;
        alu_fn = 3'(o.fn); alu_we = o.awe; alu_src = 3'(o.asrc); alu_dst = 3'(o.adst);
        add_we = o.dwe; add_src = 3'(o.dsrc); add_dst = 3'(o.ddst);
        add_three = o.three; add_neg = o.neg; swap = o.swp; sat_en = o.sat;
    endtask

    // Independent arithmetic model of one issued command (R2..R6, R8, R9).
    task automatic model(op_t o);
        longint p0, p1, pa, pb, a1, a2, ra, rs, t;
        bit ca, cs;
        p0 = longint'($signed(o.x[31:16])) * longint'($signed(o.y[31:16]));
        p1 = longint'($signed(o.x[15:0]))  * longint'($signed(o.y[15:0]));
        pa = o.swp ? p1 : p0;
        pb = o.swp ? p0 : p1;
        a1 = m_acc[o.asrc];
        a2 = m_acc[o.dsrc];
        ca = 0;
        case (o.fn)
            0: ra = lim(a1 + pa, o.sat, ca);
            1: ra = lim(a1 - pa, o.sat, ca);
            2: ra = a1 & pa;
            3: ra = a1 | pa;
            4: ra = a1 ^ pa;
            5: ra = lim(pa, o.sat, ca);
            default: ra = a1;
        endcase
        t  = o.neg ? -pb : pb;
        rs = a2 + t;
        if (o.three) rs = rs + (o.neg ? -pa : pa);
        rs = lim(rs, o.sat, cs);
        if (o.awe) m_acc[o.adst] = ra;
        if (o.dwe) m_acc[o.ddst] = rs;
        if ((o.awe && ca) || (o.dwe && cs)) m_ovf = 1;
    endtask

    task automatic run_op(op_t o, bit s);
        @(negedge clk);
        drive(o, 1'b1);
        @(negedge clk);
        issue = 1'b0;
        // R7: one edge after issue the destinations still hold old values
        rd_chk(o.adst, 1'b0, "R7 early");
        @(negedge clk);
        model(o);
        rd_chk(o.adst, s, "R2 R3 R4 R6 R10 alu");
        rd_chk(o.ddst, s, "R2 R3 R5 R6 R8 R10 add");
        check("R9 ovf", longint'(ovf), longint'(m_ovf));
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        shortint vals[8] = '{16'sd0, 16'sd1, -16'sd1, 16'sd32767, -16'sd32768,
                             16'sd12345, -16'sd20000, 16'sd256};
        op_t o, o2;
        rst = 1; rd_sat = 0; rd_sel_a = 0; rd_sel_b = 0;
        o = '{x:32'h0, y:32'h0, fn:0, awe:0, asrc:0, adst:0, dwe:0, dsrc:0, ddst:0,
              three:0, neg:0, swp:0, sat:0};
        drive(o, 1'b0);
        foreach (m_acc[k]) m_acc[k] = 0;
        m_ovf = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        for (int k = 0; k < 8; k++) rd_chk(k, 1'b0, "R1 reset");
        check("R1 ovf", longint'(ovf), 0);

        // R8 boundary: -(2^30) - (2^30) with saturation lands exactly on the low bound
        o = '{x:32'h80008000, y:32'h80008000, fn:6, awe:0, asrc:0, adst:1, dwe:1,
              dsrc:0, ddst:2, three:1, neg:1, swp:0, sat:1};
        run_op(o, 1'b0);
        // R8: without saturation 2^31 is kept, wrapping only at 40 bits
        o.ddst = 3; o.neg = 0; o.sat = 0;
        run_op(o, 1'b0);
        check("R9 no clip", longint'(ovf), 0);
        // R8: with saturation 2^31 clamps to the high bound, R9 flag rises
        o.ddst = 4; o.sat = 1;
        run_op(o, 1'b0);
        check("R9 set", longint'(ovf), 1);

        // R11: operand and command changes without issue are ignored
        o = '{x:32'h7FFF7FFF, y:32'h7FFF8000, fn:0, awe:1, asrc:3, adst:3, dwe:1,
              dsrc:3, ddst:5, three:1, neg:0, swp:1, sat:0};
        @(negedge clk); drive(o, 1'b0);
        repeat (3) @(negedge clk);
        for (int k = 0; k < 8; k++) rd_chk(k, 1'b0, "R11 idle");
        // R11: issued command with both write enables low
        o.awe = 0; o.dwe = 0;
        run_op(o, 1'b0);
        for (int k = 0; k < 8; k++) rd_chk(k, 1'b0, "R11 no write");

        // Near-exhaustive sweep over operand extremes, functions, routes and modes
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                o.x = {vals[i], vals[j]};
                o.y = {vals[j], vals[(i + 3) % 8]};
                o.fn = (i + j) % 8;
                o.awe = 1; o.asrc = i; o.adst = (i + j + 1) % 8;
                o.dwe = 1; o.dsrc = j; o.ddst = (i * 3 + j) % 8;
                o.three = ((i ^ j) & 1) != 0;
                o.neg = ((j >> 1) & 1) != 0;
                o.swp = (((i + j) >> 1) & 1) != 0;
                o.sat = ((i + 2 * j) % 3) != 0;
                run_op(o, ((i + j) & 1) != 0);
            end
        end

        // R7: back-to-back issue, second command reads the first one's result
        o = '{x:32'h01230456, y:32'h7FFF0002, fn:0, awe:1, asrc:6, adst:6, dwe:1,
              dsrc:7, ddst:7, three:0, neg:0, swp:0, sat:0};
        o2 = '{x:32'hFFFF8000, y:32'h00030003, fn:1, awe:1, asrc:6, adst:6, dwe:1,
               dsrc:7, ddst:7, three:1, neg:1, swp:1, sat:0};
        @(negedge clk); drive(o, 1'b1);
        @(negedge clk); drive(o2, 1'b1);
        @(negedge clk); issue = 1'b0;
        @(negedge clk);
        model(o);
        model(o2);
        rd_chk(6, 1'b0, "R7 chain alu");
        rd_chk(7, 1'b0, "R7 chain add");

        // R6: both units target one accumulator, the adder result is kept
        o = '{x:32'h00050007, y:32'h00030002, fn:5, awe:1, asrc:0, adst:2, dwe:1,
              dsrc:1, ddst:2, three:0, neg:0, swp:0, sat:0};
        run_op(o, 1'b0);

        // R10: saturating read leaves stored values intact
        for (int k = 0; k < 8; k++) rd_chk(k, 1'b1, "R10 sat read");
        for (int k = 0; k < 8; k++) rd_chk(k, 1'b0, "R10 raw read");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule